// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block sits on the request path of a DMA-style engine. It holds a small set of programmable address windows. It steers each outgoing request to the target that owns the address. Every window has an enable, a two-bit permission field, a base word and a size mask. Each request address is compared against all enabled windows using only its upper 16 bits. The decoder then reports whether a window was hit, which window won, and the target attribute byte of that window.

A request that matches no window is flagged as a decode miss. A request that matches a window whose permission field does not allow the access is flagged as a violation. In both cases the request is not forwarded. An override register can replace the upper 16 address bits before decoding, and writing zero to it turns the override off. The window registers are written and read through a plain register port: a write strobe, an index and data, with combinational read data.

Top module: `awd_decoder`

## Requirements
- R1: After reset every register reads 0, so every window is disabled and any request yields a miss.
- R2: Register index 0 is the control word and index 1 is the override. Window i owns index 2+2i (base) and index 3+2i (size mask). A written word reads back unchanged at its index, and unmapped indices read 0.
- R3: Window i matches when enabled and (addr[31:16] XOR base[31:16]) AND NOT mask[31:16] is zero, where a mask bit of 1 ignores that address bit. Mask 0x0FFF spans 256 MB and mask 0x03FF spans 64 MB. Results appear on the outputs one clock after req_valid.
- R4: Control-word bit i enables window i. A window whose enable bit is 0 never hits.
- R5: When several windows match, the lowest-indexed one wins.
- R6: On a hit, dec_win carries the winning index and dec_attr carries bits [15:8] of its base word (chip selects are one-cold: 0x0E, 0x0D, 0x0B, 0x07; on-chip SRAM uses 0x1E).
- R7: With no matching window, dec_miss is 1, dec_hit is 0, dec_win and dec_attr are 0, and nothing is forwarded.
- R8: Control bits [16+2i] (read allowed) and [17+2i] (write allowed) form window i's permission field, and 2'b11 grants full access. A write without write permission, or a read without read permission, raises dec_viol for one cycle, and fwd_valid stays 0.
- R9: Override bit 0 set replaces the request's upper 16 bits with override bits [31:16] before decoding, and fwd_addr carries the resulting address. With the override register at zero, the address passes through unchanged.
- R10: In a cycle following no request, all decode outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register index for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data at reg_addr |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for a write request, 0 for a read |
| req_addr | input | 32 | Request address |
| dec_valid | output | 1 | Decode result valid |
| dec_hit | output | 1 | A window matched |
| dec_miss | output | 1 | No window matched |
| dec_viol | output | 1 | Permission violation |
| dec_win | output | IW | Winning window index |
| dec_attr | output | 8 | Target attribute of the winner |
| fwd_valid | output | 1 | Request forwarded |
| fwd_addr | output | 32 | Forwarded (possibly overridden) address |

## Verification
The bench starts with addresses placed inside each of the five windows and just past the edge of the 64 MB SRAM window. These separate correct mask handling from an off-by-one in the ignored bits. Overlapping windows, first with both enabled and then with the lower one disabled, tell lowest-index priority apart from any other ordering and from a missing enable check. Read and write requests against each permission code separate the read bit from the write bit. An override on, then cleared, shows the address substitution and its removal. A pseudo-random sweep of mixed reads and writes across the map is compared cycle by cycle against a behavioural model.

// File: rtl/awd_pkg.sv
package awd_pkg;
   // register map indices
   localparam int CTRL_IDX = 0;
   localparam int OVR_IDX  = 1;
   localparam int WIN_IDX0 = 2;

   typedef struct packed {
      logic        en;
      logic [1:0]  perm;   // [0] read allowed, [1] write allowed
      logic [15:0] base;
      logic [15:0] mask;   // 1 = address bit ignored
      logic [7:0]  attr;
   } win_cfg_t;
endpackage

// File: rtl/awd_regs.sv
module awd_regs
   import awd_pkg::*;
#(
   parameter int NUM_WIN = 5,
   parameter int REG_AW  = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       reg_we,
   input  logic [REG_AW-1:0]          reg_addr,
   input  logic [31:0]                reg_wdata,
   output logic [31:0]                reg_rdata,
   output win_cfg_t [NUM_WIN-1:0]     cfg_o,
   output logic [31:0]                ovr_o
);
   logic [31:0] ctrl_q;
   logic [31:0] ovr_q;
   logic [31:0] base_q [NUM_WIN];
   logic [31:0] mask_q [NUM_WIN];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         ovr_q  <= '0;
         for (int i = 0; i < NUM_WIN; i++) begin
            base_q[i] <= '0;
            mask_q[i] <= '0;
         end
      end else if (reg_we) begin
         if (reg_addr == REG_AW'(CTRL_IDX)) ctrl_q <= reg_wdata;
         if (reg_addr == REG_AW'(OVR_IDX))  ovr_q  <= reg_wdata;
         for (int i = 0; i < NUM_WIN; i++) begin
            if (reg_addr == REG_AW'(WIN_IDX0 + 2*i))     base_q[i] <= reg_wdata;
            if (reg_addr == REG_AW'(WIN_IDX0 + 2*i + 1)) mask_q[i] <= reg_wdata;
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == REG_AW'(CTRL_IDX)) reg_rdata = ctrl_q;
      if (reg_addr == REG_AW'(OVR_IDX))  reg_rdata = ovr_q;
      for (int i = 0; i < NUM_WIN; i++) begin
         if (reg_addr == REG_AW'(WIN_IDX0 + 2*i))     reg_rdata = base_q[i];
         if (reg_addr == REG_AW'(WIN_IDX0 + 2*i + 1)) reg_rdata = mask_q[i];
      end
   end

   for (genvar g = 0; g < NUM_WIN; g++) begin : g_cfg
      assign cfg_o[g].en   = ctrl_q[g];
      assign cfg_o[g].perm = ctrl_q[16 + 2*g +: 2];
      assign cfg_o[g].base = base_q[g][31:16];
      assign cfg_o[g].attr = base_q[g][15:8];
      assign cfg_o[g].mask = mask_q[g][31:16];
   end

   assign ovr_o = ovr_q;

   // R9
   ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == REG_AW'(OVR_IDX) && reg_wdata == '0) |=> (ovr_o == '0));
endmodule

// File: rtl/awd_win_match.sv
module awd_win_match
   import awd_pkg::*;
(
   input  win_cfg_t    cfg,
   input  logic [15:0] addr_hi,
   output logic        hit
);
   assign hit = cfg.en && (((addr_hi ^ cfg.base) & ~cfg.mask) == 16'h0000);
endmodule

// File: rtl/awd_prio.sv
module awd_prio #(
   parameter int N  = 5,
   parameter int IW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   output logic [N-1:0]  grant,
   output logic [IW-1:0] idx,
   output logic          any
);
   always_comb begin
      grant = '0;
      idx   = '0;
      for (int i = N-1; i >= 0; i--) begin
         if (req[i]) begin
            grant    = '0;
            grant[i] = 1'b1;
            idx      = IW'(i);
         end
      end
   end
   assign any = |req;

   // R5
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   // R5
   grant_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((grant & ~req) == '0) && (any == (grant != '0)));
endmodule

// File: rtl/awd_decoder.sv
module awd_decoder
   import awd_pkg::*;
#(
   parameter int NUM_WIN = 5,
   parameter bit OVR_EN  = 1'b1,
   localparam int IW     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
   localparam int REG_AW = $clog2(WIN_IDX0 + 2*NUM_WIN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [31:0]       req_addr,
   output logic              dec_valid,
   output logic              dec_hit,
   output logic              dec_miss,
   output logic              dec_viol,
   output logic [IW-1:0]     dec_win,
   output logic [7:0]        dec_attr,
   output logic              fwd_valid,
   output logic [31:0]       fwd_addr
);
   // enables live in bits [NUM_WIN-1:0], permissions in [31:16]
   if (NUM_WIN < 1 || NUM_WIN > 8) begin : g_bad_num_win
      $error("awd_decoder: NUM_WIN must be 1..8");
   end

   win_cfg_t [NUM_WIN-1:0] cfg;
   logic [31:0]            ovr;
   logic [31:0]            eff_addr;
   logic [NUM_WIN-1:0]     match;
   logic [NUM_WIN-1:0]     grant;
   logic [IW-1:0]          win_idx;
   logic                   any_hit;
   logic [7:0]             win_attr;
   logic [1:0]             win_perm;
   logic                   viol;

   awd_regs #(.NUM_WIN(NUM_WIN), .REG_AW(REG_AW)) regs_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg_o(cfg), .ovr_o(ovr)
   );

   if (OVR_EN) begin : g_ovr
      assign eff_addr = ovr[0] ? {ovr[31:16], req_addr[15:0]} : req_addr;
   end else begin : g_no_ovr
      logic unused_ovr;
      assign unused_ovr = ^ovr;
      assign eff_addr   = req_addr;
   end

   for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
      awd_win_match match_i (.cfg(cfg[g]), .addr_hi(eff_addr[31:16]), .hit(match[g]));
   end

   awd_prio #(.N(NUM_WIN), .IW(IW)) prio_i (
      .clk(clk), .rst_n(rst_n), .req(match), .grant(grant), .idx(win_idx), .any(any_hit)
   );

   always_comb begin
      win_attr = '0;
      win_perm = '0;
      for (int i = 0; i < NUM_WIN; i++) begin
         if (grant[i]) begin
            win_attr = win_attr | cfg[i].attr;
            win_perm = win_perm | cfg[i].perm;
         end
      end
   end

   assign viol = any_hit && (req_write ? !win_perm[1] : !win_perm[0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid <= 1'b0;
         dec_hit   <= 1'b0;
         dec_miss  <= 1'b0;
         dec_viol  <= 1'b0;
         dec_win   <= '0;
         dec_attr  <= '0;
         fwd_valid <= 1'b0;
         fwd_addr  <= '0;
      end else begin
         dec_valid <= req_valid;
         dec_hit   <= req_valid && any_hit;
         dec_miss  <= req_valid && !any_hit;
         dec_viol  <= req_valid && viol;
         dec_win   <= (req_valid && any_hit) ? win_idx : '0;
         dec_attr  <= (req_valid && any_hit) ? win_attr : '0;
         fwd_valid <= req_valid && any_hit && !viol;
         fwd_addr  <= (req_valid && any_hit && !viol) ? eff_addr : '0;
      end
   end

   // R3
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> dec_valid);
   // R7
   hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |-> (dec_hit != dec_miss));
   // R7
   miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_miss |-> (!fwd_valid && dec_attr == '0 && dec_win == '0));
   // R8
   viol_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_viol |-> (dec_hit && !fwd_valid));
   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |-> !(dec_hit || dec_miss || dec_viol || fwd_valid));
   // R6
   win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_hit |-> (int'(dec_win) < NUM_WIN));
endmodule

// File: tb/awd_decoder_tb_top.sv
module awd_decoder_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NW  = 5;
   localparam int IW  = 3;
   localparam int RAW = 4;
   localparam int NREG = 2 + 2*NW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_we = 1'b0;
   logic [RAW-1:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [31:0] req_addr = '0;
   logic dec_valid, dec_hit, dec_miss, dec_viol, fwd_valid;
   logic [IW-1:0] dec_win;
   logic [7:0] dec_attr;
   logic [31:0] fwd_addr;

   awd_decoder #(.NUM_WIN(NW)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
      .req_write(req_write), .req_addr(req_addr), .dec_valid(dec_valid),
      .dec_hit(dec_hit), .dec_miss(dec_miss), .dec_viol(dec_viol),
      .dec_win(dec_win), .dec_attr(dec_attr), .fwd_valid(fwd_valid),
      .fwd_addr(fwd_addr)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int total = 0, bad = 0;
   bit finished = 0;
   logic [31:0] sh [0:15];
   logic [47:0] exp_v;
   bit have_exp = 0;
   string exp_tag = "R1";

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      total++; bad++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      summary();
   end

   // behavioural reference for one decode
   function automatic logic [47:0] model(input logic rv, input logic rw, input logic [31:0] a);
      logic [31:0] eff;
      int w;
      logic [1:0] pm;
      logic vi;
      if (!rv) return '0;
      eff = sh[1][0] ? {sh[1][31:16], a[15:0]} : a;
      w = -1;
      for (int i = NW-1; i >= 0; i--) begin
         if (sh[0][i] && (((eff[31:16] ^ sh[2+2*i][31:16]) & ~sh[3+2*i][31:16]) == 16'h0))
            w = i;
      end
      if (w < 0) return {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 8'd0, 32'd0};
      pm = sh[0][16+2*w +: 2];
      vi = rw ? !pm[1] : !pm[0];
      return {1'b1, 1'b1, 1'b0, vi, !vi, 3'(w), sh[2+2*w][15:8], vi ? 32'd0 : eff};
   endfunction

   task automatic check_out();
      logic [47:0] act;
      act = {dec_valid, dec_hit, dec_miss, dec_viol, fwd_valid, dec_win, dec_attr, fwd_addr};
      if (have_exp) begin
         total++;
         if (act !== exp_v) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", exp_tag, act, exp_v);
         end
      end
   endtask

   task automatic step(input logic we, input logic [RAW-1:0] wa, input logic [31:0] wd,
                       input logic rv, input logic rw, input logic [31:0] ra, input string tag);
      @(negedge clk);
      check_out();
      exp_v = model(rv, rw, ra);
      exp_tag = tag;
      have_exp = 1;
      reg_we = we; reg_addr = wa; reg_wdata = wd;
      req_valid = rv; req_write = rw; req_addr = ra;
      if (we && int'(wa) < NREG) sh[wa] = wd;
   endtask

   task automatic wr(input int a, input logic [31:0] d, input string tag);
      step(1'b1, RAW'(a), d, 1'b0, 1'b0, 32'd0, tag);
   endtask

   task automatic rq(input logic [31:0] a, input logic w, input string tag);
      step(1'b0, '0, 32'd0, 1'b1, w, a, tag);
   endtask

   task automatic rd(input int a, input string tag);
      logic [31:0] e;
      step(1'b0, RAW'(a), 32'd0, 1'b0, 1'b0, 32'd0, "R10");
      #1;
      e = (a < NREG) ? sh[a] : 32'd0;
      total++;
      if (reg_rdata !== e) begin
         bad++;
         $display("FAIL %s: reg %0d actual=%h expected=%h", tag, a, reg_rdata, e);
      end
   endtask

   initial begin
      logic [31:0] lcg;
      for (int i = 0; i < 16; i++) sh[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      exp_v = '0; have_exp = 1; exp_tag = "R1";
      // R1: reset state
      for (int i = 0; i < 16; i++) rd(i, "R1");
      rq(32'h0000_0000, 1'b0, "R1");
      rq(32'h4000_0000, 1'b1, "R1");
      // R2: program map: 4 chip-select windows + SRAM
      wr(2, 32'h0000_0E00, "R2"); wr(3, 32'h0FFF_0000, "R2");
      wr(4, 32'h1000_0D00, "R2"); wr(5, 32'h0FFF_0000, "R2");
      wr(6, 32'h2000_0B00, "R2"); wr(7, 32'h0FFF_0000, "R2");
      wr(8, 32'h3000_0700, "R2"); wr(9, 32'h0FFF_0000, "R2");
      wr(10, 32'h4000_1E00, "R2"); wr(11, 32'h03FF_0000, "R2");
      wr(0, 32'h03FF_001F, "R2");
      wr(14, 32'hDEAD_BEEF, "R2");
      for (int i = 0; i < 16; i++) rd(i, "R2");
      // R3 / R6: one address in each window, SRAM edge
      rq(32'h0123_4567, 1'b0, "R6");
      rq(32'h1FFF_0000, 1'b1, "R6");
      rq(32'h2800_0000, 1'b0, "R6");
      rq(32'h3000_0004, 1'b1, "R6");
      rq(32'h43FF_FFFF, 1'b0, "R3");
      rq(32'h4400_0000, 1'b0, "R3");
      rq(32'h5000_0000, 1'b1, "R7");
      rq(32'hF000_0000, 1'b0, "R7");
      // R10: idle cycles
      step(1'b0, '0, 32'd0, 1'b0, 1'b0, 32'd0, "R10");
      step(1'b0, '0, 32'd0, 1'b0, 1'b0, 32'd0, "R10");
      // R4: disabled window
      wr(0, 32'h03FF_001B, "R4");
      rq(32'h2000_0000, 1'b0, "R4");
      rq(32'h2FFF_FFFF, 1'b1, "R4");
      wr(0, 32'h03FF_001F, "R4");
      rq(32'h2000_0000, 1'b0, "R4");
      // R5: overlap win0 and win1
      wr(4, 32'h0000_0D00, "R5");
      rq(32'h0100_0000, 1'b0, "R5");
      wr(0, 32'h03FF_001E, "R5");
      rq(32'h0100_0000, 1'b0, "R5");
      wr(0, 32'h03FF_001F, "R5");
      wr(4, 32'h1000_0D00, "R5");
      // R8: permissions on SRAM window
      wr(0, 32'h01FF_001F, "R8");
      rq(32'h4000_0100, 1'b1, "R8");
      rq(32'h4000_0100, 1'b0, "R8");
      wr(0, 32'h02FF_001F, "R8");
      rq(32'h4000_0100, 1'b0, "R8");
      rq(32'h4000_0100, 1'b1, "R8");
      wr(0, 32'h00FF_001F, "R8");
      rq(32'h4000_0100, 1'b0, "R8");
      rq(32'h4000_0100, 1'b1, "R8");
      wr(0, 32'h03FF_001F, "R8");
      // R9: override
      wr(1, 32'h2000_0001, "R9");
      rq(32'h0000_0010, 1'b1, "R9");
      rq(32'hF000_ABCD, 1'b0, "R9");
      wr(1, 32'h3000_0000, "R9");
      rq(32'h0000_0010, 1'b0, "R9");
      wr(1, 32'h0000_0000, "R9");
      rd(1, "R9");
      rq(32'h0000_0010, 1'b1, "R9");
      // mixed sweep
      wr(0, 32'h01BF_001F, "R8");
      lcg = 32'h1234_5678;
      for (int n = 0; n < 300; n++) begin
         lcg = lcg * 32'd1103515245 + 32'd12345;
         if (n % 7 == 3) step(1'b0, '0, 32'd0, 1'b0, 1'b0, 32'd0, "R10");
         else rq({1'b0, lcg[30:0] ^ {lcg[6:0], 24'h0}}, lcg[3], "R3");
      end
      step(1'b0, '0, 32'd0, 1'b0, 1'b0, 32'd0, "R10");
      step(1'b0, '0, 32'd0, 1'b0, 1'b0, 32'd0, "R10");
      summary();
   end
endmodule